// File: doc/BRIEF.md
# Receive Gain Step Controller

This block converts a receive gain request from the baseband processor into two thermometer-coded switch words. One word drives a coarse front-end gain stage. The other drives a fine baseband amplifier whose degeneration branches change the gain in 2 dB steps. Each coarse step equals one full run of the fine stage: four fine steps of 2 dB each, 8 dB in total. A gain index therefore names a total gain in 2 dB units above the lowest setting.

At the same clock edge as each gain change, the block also delivers a DC-offset correction word. This word comes from a small table with one entry per gain index, and a calibration port loads it. The two switch words and the offset word are registered together, so the analog side never sees a gain from one setting paired with an offset from another.

Some totals can be reached with two different coarse levels. When the index lands on such a boundary value, the coarse level stays where it is. This gives one fine step of hysteresis and keeps the coarse switch from chattering.

Top module: `rx_gain_step_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both switch words and the offset word become zero and every table entry is cleared to zero.
- R2: `bb_code` is a thermometer code. Bit 0 fills first, and the number of ones is the fine level, 0 to FINE_STEPS.
- R3: `fe_code` is a thermometer code. Bit 0 fills first, and the number of ones is the coarse level, 0 to COARSE_STEPS.
- R4: The coarse level times FINE_STEPS plus the fine level equals the clamped gain index sampled at the previous edge.
- R5: If the clamped index is above the range of the current coarse level, the new coarse level is the lowest level whose range holds the index. The fine stage therefore runs full before the coarse stage rises.
- R6: If the clamped index is below the range of the current coarse level, the new coarse level is the highest level whose range holds the index. The fine stage therefore empties before the coarse stage falls.
- R7: Each coarse level c covers indices c*FINE_STEPS to c*FINE_STEPS+FINE_STEPS. An index inside that range, including a shared boundary value, leaves the coarse level unchanged.
- R8: A gain index above COARSE_STEPS*FINE_STEPS+FINE_STEPS (20 by default) is treated as that maximum.
- R9: `dco_word` is the table entry addressed by the clamped gain index, registered at the same edge as both switch words.
- R10: A table write stores `cal_data` at entry `cal_addr` when `cal_we` is high at an edge. A write whose address is above the maximum index is ignored.
- R11: If a write hits the entry that the same edge selects, `dco_word` takes the newly written data at that edge.
- R12: All outputs change only at a clock edge. A new index has no effect on the outputs before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gain_idx | input | IDX_W | Requested total gain in fine steps |
| cal_we | input | 1 | Offset table write strobe |
| cal_addr | input | IDX_W | Offset table write address (gain index) |
| cal_data | input | OFS_W | Offset correction value to store |
| fe_code | output | COARSE_STEPS | Front-end thermometer switch word |
| bb_code | output | FINE_STEPS | Baseband amplifier thermometer switch word |
| dco_word | output | OFS_W | DC-offset correction for the active setting |

## Verification
In a single edge, the calibration port can write the very entry that the gain decode is selecting. The bench provokes this directly, by writing the entry for the index it requests at that edge. It also lets random traffic hit the same collision, with writes issued at random addresses alongside random indices. In each case the bench expects `dco_word` to carry the freshly written value, while the switch words follow the hysteresis rule independently. A write to an out-of-range address paired with an over-range index is also judged: the clamped entry must stay untouched.

// File: rtl/rx_gain_step_ctrl.sv
module rx_gain_step_ctrl #(
  parameter int FINE_STEPS   = 4,
  parameter int COARSE_STEPS = 4,
  parameter int IDX_W        = 5,
  parameter int OFS_W        = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        gain_idx,
  input  logic                    cal_we,
  input  logic [IDX_W-1:0]        cal_addr,
  input  logic [OFS_W-1:0]        cal_data,
  output logic [COARSE_STEPS-1:0] fe_code,
  output logic [FINE_STEPS-1:0]   bb_code,
  output logic [OFS_W-1:0]        dco_word
);
  localparam int TOP_IDX = COARSE_STEPS * FINE_STEPS + FINE_STEPS;
  localparam int DEPTH   = TOP_IDX + 1;
  localparam int CL_W    = $clog2(COARSE_STEPS + 1);
  localparam int FL_W    = $clog2(FINE_STEPS + 1);

  logic [CL_W-1:0]  crs_q, crs_n;
  logic [FL_W-1:0]  fin_q, fin_n;
  logic [IDX_W-1:0] sel;
  logic             hit;
  logic [OFS_W-1:0] tbl [DEPTH];

  assign sel = (int'(gain_idx) > TOP_IDX) ? IDX_W'(TOP_IDX) : gain_idx;
  assign hit = cal_we && (cal_addr == sel);

  always_comb begin
    int g, lo, cn;
    g  = int'(sel);
    lo = int'(crs_q) * FINE_STEPS;
    if (g > lo + FINE_STEPS) cn = (g - 1) / FINE_STEPS;
    else if (g < lo)         cn = g / FINE_STEPS;
    else                     cn = int'(crs_q);
    crs_n = CL_W'(cn);
    fin_n = FL_W'(g - cn * FINE_STEPS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_q    <= '0;
      fin_q    <= '0;
      dco_word <= '0;
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      crs_q    <= crs_n;
      fin_q    <= fin_n;
      dco_word <= hit ? cal_data : tbl[sel];
      if (cal_we && int'(cal_addr) <= TOP_IDX) tbl[cal_addr] <= cal_data;
    end
  end

  assign fe_code = COARSE_STEPS'((1 << crs_q) - 1);
  assign bb_code = FINE_STEPS'((1 << fin_q) - 1);

  p_fine_thermo_r2: assert property (@(posedge clk) disable iff (rst)
    (bb_code & (bb_code + 1'b1)) == '0);
  p_coarse_thermo_r3: assert property (@(posedge clk) disable iff (rst)
    (fe_code & (fe_code + 1'b1)) == '0);
  p_total_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(fe_code) * FINE_STEPS + $countones(bb_code)) == int'($past(sel)));
  p_fill_first_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) > int'(crs_q) * FINE_STEPS + FINE_STEPS) |=> bb_code != '0);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(sel) >= int'(crs_q) * FINE_STEPS && int'(sel) <= int'(crs_q) * FINE_STEPS + FINE_STEPS)
    |=> $stable(fe_code));
  p_clamp_r8: assert property (@(posedge clk) disable iff (rst)
    (int'(gain_idx) > TOP_IDX) |=> ($countones(fe_code) * FINE_STEPS + $countones(bb_code)) == TOP_IDX);
  p_bypass_r11: assert property (@(posedge clk) disable iff (rst)
    hit |=> dco_word == $past(cal_data));
endmodule

// File: tb/rx_gain_step_ctrl_test.sv
module rx_gain_step_ctrl_test;
  localparam int F = 4, C = 4, TOP = C * F + F;

  logic       clk = 1'b0, rst = 1'b1, cal_we = 1'b0;
  logic [4:0] gain_idx = '0, cal_addr = '0;
  logic [7:0] cal_data = '0, dco_word;
  logic [3:0] fe_code, bb_code;

  int n_chk = 0, n_bad = 0;
  int m_crs = 0, m_fin = 0, m_dco = 0;
  int m_tbl [TOP+1];

  always #2 clk = ~clk;

  rx_gain_step_ctrl uut (.clk(clk), .rst(rst), .gain_idx(gain_idx), .cal_we(cal_we),
    .cal_addr(cal_addr), .cal_data(cal_data), .fe_code(fe_code), .bb_code(bb_code),
    .dco_word(dco_word));

  function automatic int therm(int n);
    return (1 << n) - 1;
  endfunction

  function automatic int next_crs(int c, int g);
    if (g > c * F + F) return (g - 1) / F;
    if (g < c * F) return g / F;
    return c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int idx, bit we, int addr, int dat, string tag);
    int g, cn, ed;
    gain_idx = 5'(idx); cal_we = we; cal_addr = 5'(addr); cal_data = 8'(dat);
    #1;
    chk({tag, " R12 coarse before edge"}, int'(fe_code), therm(m_crs));
    chk({tag, " R12 offset before edge"}, int'(dco_word), m_dco);
    g  = (idx > TOP) ? TOP : idx;
    cn = next_crs(m_crs, g);
    ed = (we && addr == g) ? dat : m_tbl[g];
    if (we && addr <= TOP) m_tbl[addr] = dat;
    m_crs = cn; m_fin = g - cn * F; m_dco = ed;
    @(negedge clk);
    chk({tag, " R3 coarse"}, int'(fe_code), therm(m_crs));
    chk({tag, " R2 fine"}, int'(bb_code), therm(m_fin));
    chk({tag, " R4 total"}, $countones(fe_code) * F + $countones(bb_code), g);
    chk({tag, " R9 offset"}, int'(dco_word), m_dco);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    foreach (m_tbl[i]) m_tbl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset coarse", int'(fe_code), 0);
    chk("R1 reset fine", int'(bb_code), 0);
    chk("R1 reset offset", int'(dco_word), 0);
    rst = 1'b0;
    step(13, 0, 0, 0, "R1 cleared table");
    step(0, 0, 0, 0, "R6 back to zero");
    for (int i = 0; i <= TOP; i++) step(0, 1, i, (i * 11 + 3) & 255, "R10 cal");
    step(13, 0, 0, 0, "R5 rise");
    step(3, 0, 0, 0, "R6 fall");
    step(4, 0, 0, 0, "R7 boundary up");
    step(5, 0, 0, 0, "R5 next coarse");
    step(4, 0, 0, 0, "R7 boundary down");
    step(3, 0, 0, 0, "R6 below range");
    step(31, 0, 0, 0, "R8 clamp max");
    step(21, 1, 25, 99, "R10 ignore high addr");
    step(25, 0, 0, 0, "R10 entry intact");
    step(9, 0, 0, 0, "R6 drop");
    step(7, 1, 7, 200, "R11 bypass");
    step(7, 0, 0, 0, "R11 stored");
    step(20, 1, 20, 77, "R11 bypass at max");
    for (int k = 0; k < 400; k++)
      step(int'($urandom % 32), ($urandom % 4) == 0, int'($urandom % 32),
           int'($urandom % 256), "R5/R6 random");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule